// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the arithmetic stage of a small 64-bit processor. Each cycle it combines two operands with one of four integer functions (add, subtract, bitwise and, bitwise exclusive-or) and presents the result combinationally. The first operand is the source register value `a_val`. The second operand `b_val` is the destination register value, which the result overwrites. Subtraction yields `b_val - a_val`.

Three status bits are kept in a register: overflow, zero and sign. They are captured from the operation on the current cycle at a rising clock edge, but only when `set_flags` is high. Control logic raises `set_flags` only for the four arithmetic/logical instructions.

From the stored flags, the block evaluates one of seven conditions selected by `cond_fn`. The same condition codes serve conditional jumps and conditional register moves. Code 0 is always true, so it covers the plain jump and the plain move. The reset is asynchronous and active-low. It is released through an internal two-stage synchronizer.

Top module: `alu_cc_unit`

## Requirements
- R1: With `alu_fn` = 0, `result` equals `b_val + a_val` modulo 2^64, combinationally.
- R2: With `alu_fn` = 1, `result` equals `b_val - a_val` modulo 2^64.
- R3: With `alu_fn` = 2, `result` is `b_val & a_val`; with `alu_fn` = 3, it is `b_val ^ a_val`.
- R4: At a rising edge with `set_flags` high, `flag_zf` becomes 1 exactly when `result` is zero, and `flag_sf` becomes bit 63 of `result`.
- R5: For an add with `set_flags` high, `flag_of` becomes 1 only when both operands have the same sign bit and the result sign differs from it.
- R6: For a subtract, `flag_of` becomes 1 only when `b_val` and `a_val` differ in sign and the result sign differs from `b_val`. For and/xor, `flag_of` becomes 0.
- R7: At an edge with `set_flags` low, all three flags keep their values, whatever the operands and function.
- R8: While reset is active and after its release, with no flag update yet, the flags read `flag_zf` = 1, `flag_sf` = 0 and `flag_of` = 0.
- R9: `cond_true` follows the stored flags. Code 0 gives 1. Code 1 gives (SF^OF)|ZF. Code 2 gives SF^OF. Code 3 gives ZF. Code 4 gives !ZF. Code 5 gives !(SF^OF). Code 6 gives !(SF^OF)&!ZF.
- R10: `cond_fn` values 7 to 15 give `cond_true` = 0 for every flag state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_val | input | 64 | Source operand |
| b_val | input | 64 | Destination operand (minuend for subtract) |
| alu_fn | input | 2 | 0 add, 1 subtract, 2 and, 3 xor |
| set_flags | input | 1 | Capture flags from this operation at the next edge |
| cond_fn | input | 4 | Condition selector, 0..6 valid |
| result | output | 64 | Operation result |
| flag_of | output | 1 | Stored overflow flag |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored sign flag |
| cond_true | output | 1 | Selected condition evaluated on stored flags |

## Verification
The hardest states to reach are the signed-overflow flag combinations. The greater and less-or-equal conditions only separate from the plain sign test when OF is 1 together with SF, or together with ZF. The stimulus reaches these states with operands at the two's-complement extremes. Examples are the largest positive value plus one, the most negative value minus one, and a sum that wraps to exactly zero with overflow set. After each such update, all sixteen condition codes are swept with flag updates disabled. The same sweep also shows that the stored flags do not move while the operands keep changing.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } alu_fn_e;

  localparam int unsigned CND_W = 4;

  typedef enum logic [CND_W-1:0] {
    CND_ALWAYS = 4'd0,
    CND_LE     = 4'd1,
    CND_LT     = 4'd2,
    CND_EQ     = 4'd3,
    CND_NE     = 4'd4,
    CND_GE     = 4'd5,
    CND_GT     = 4'd6
  } cnd_fn_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic sign;
  } cc_t;

  localparam cc_t CC_RESET = '{ovf: 1'b0, zero: 1'b1, sign: 1'b0};

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output cc_t          cc_next
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] sum_v;
  logic [W-1:0] dif_v;
  logic         ovf_v;

  always_comb begin
    sum_v = src_b + src_a;
    dif_v = src_b - src_a;
    unique case (fn)
      ALU_ADD: res = sum_v;
      ALU_SUB: res = dif_v;
      ALU_AND: res = src_b & src_a;
      default: res = src_b ^ src_a;
    endcase
  end

  always_comb begin
    unique case (fn)
      ALU_ADD: ovf_v = (src_a[MSB] == src_b[MSB]) && (sum_v[MSB] != src_b[MSB]);
      ALU_SUB: ovf_v = (src_a[MSB] != src_b[MSB]) && (dif_v[MSB] != src_b[MSB]);
      default: ovf_v = 1'b0;
    endcase
    cc_next.ovf  = ovf_v;
    cc_next.zero = (res == '0);
    cc_next.sign = res[MSB];
  end
endmodule

// File: rtl/alu_cc_reg.sv
module alu_cc_reg
  import alu_cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cc_t  cc_in,
  output cc_t  cc_q
);
  cc_t cc_d;

  always_comb begin
    cc_d = cc_q;
    if (load) cc_d = cc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= CC_RESET;
    else        cc_q <= cc_d;
  end

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cc_q));
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_cc_pkg::*;
(
  input  cc_t              cc,
  input  logic [CND_W-1:0] sel,
  output logic             hit
);
  logic lt_v;

  always_comb begin
    lt_v = cc.sign ^ cc.ovf;
    case (cnd_fn_e'(sel))
      CND_ALWAYS: hit = 1'b1;
      CND_LE:     hit = lt_v | cc.zero;
      CND_LT:     hit = lt_v;
      CND_EQ:     hit = cc.zero;
      CND_NE:     hit = !cc.zero;
      CND_GE:     hit = !lt_v;
      CND_GT:     hit = !lt_v && !cc.zero;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] b_val,
  input  logic [1:0]   alu_fn,
  input  logic         set_flags,
  input  logic [3:0]   cond_fn,
  output logic [W-1:0] result,
  output logic         flag_of,
  output logic         flag_zf,
  output logic         flag_sf,
  output logic         cond_true
);
  logic rst_sync_n;
  cc_t  cc_next;
  cc_t  cc_cur;

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  alu_datapath #(.W(W)) u_dp (
    .src_a   (a_val),
    .src_b   (b_val),
    .fn      (alu_fn_e'(alu_fn)),
    .res     (result),
    .cc_next (cc_next)
  );

  alu_cc_reg u_cc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (set_flags),
    .cc_in (cc_next),
    .cc_q  (cc_cur)
  );

  alu_cond_eval u_cnd (
    .cc  (cc_cur),
    .sel (cond_fn),
    .hit (cond_true)
  );

  assign flag_of = cc_cur.ovf;
  assign flag_zf = cc_cur.zero;
  assign flag_sf = cc_cur.sign;

  // R4
  zero_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set_flags |=> (flag_zf == ($past(result) == '0)));

  // R4
  sign_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set_flags |=> (flag_sf == $past(result[W-1])));

  // R5
  add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_flags && alu_fn == 2'd0) |=>
      (flag_of == (($past(a_val[W-1]) == $past(b_val[W-1])) &&
                   ($past(result[W-1]) != $past(b_val[W-1])))));

  // R6
  logic_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_flags && alu_fn[1]) |=> !flag_of);

  // R10
  bad_cond_false_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cond_fn > 4'd6) |-> !cond_true);
endmodule

// File: tb/alu_cc_unit_test.sv
module alu_cc_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [63:0] a_val = '0;
  logic [63:0] b_val = '0;
  logic [1:0]  alu_fn = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  cond_fn = '0;
  logic [63:0] result;
  logic        flag_of, flag_zf, flag_sf, cond_true;

  alu_cc_unit uut (
    .clk(clk), .rst_n(rst_n), .a_val(a_val), .b_val(b_val),
    .alu_fn(alu_fn), .set_flags(set_flags), .cond_fn(cond_fn),
    .result(result), .flag_of(flag_of), .flag_zf(flag_zf),
    .flag_sf(flag_sf), .cond_true(cond_true)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    logic [63:0] res;
    bit          of, zf, sf, ct;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit m_of = 0, m_zf = 1, m_sf = 0;
  bit done = 0;

  function automatic bit model_cond(input logic [3:0] c, input bit o, input bit z, input bit s);
    bit lt = s ^ o;
    case (c)
      4'd0: return 1;
      4'd1: return lt | z;
      4'd2: return lt;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !lt;
      4'd6: return !lt && !z;
      default: return 0;
    endcase
  endfunction

  task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation at a falling edge and queues the expected outcome.
  task automatic drive(input string tag, input logic [1:0] fn, input logic [63:0] a,
                       input logic [63:0] b, input bit setf, input logic [3:0] cf);
    exp_t e;
    logic [63:0] r;
    bit o;
    @(negedge clk);
    a_val = a; b_val = b; alu_fn = fn; set_flags = setf; cond_fn = cf;
    case (fn)
      2'd0: begin r = b + a; o = (a[63] == b[63]) && (r[63] != a[63]); end
      2'd1: begin r = b - a; o = (a[63] != b[63]) && (r[63] != b[63]); end
      2'd2: begin r = b & a; o = 0; end
      default: begin r = b ^ a; o = 0; end
    endcase
    if (setf) begin
      m_of = o; m_zf = (r == 0); m_sf = r[63];
    end
    e.tag = tag; e.res = r; e.of = m_of; e.zf = m_zf; e.sf = m_sf;
    e.ct = model_cond(cf, m_of, m_zf, m_sf);
    q.push_back(e);
  endtask

  // Monitor: after each rising edge, compares the next queued item.
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check1({e.tag, " result"}, result, e.res);
        check1({e.tag, " flags"}, {61'd0, flag_of, flag_zf, flag_sf}, {61'd0, e.of, e.zf, e.sf});
        check1({e.tag, " cond"}, {63'd0, cond_true}, {63'd0, e.ct});
      end
    end
  end

  // Sweep all condition codes with flag updates off and operands changing (R7, R9, R10).
  task automatic sweep(input string tag);
    for (int c = 0; c < 16; c++) begin
      drive({tag, (c > 6) ? " R10 cond" : " R9 R7 cond"}, 2'(c), 64'h8000_0000_0000_0000 ^ 64'(c),
            64'hFFFF_0000_0000_0000 + 64'(c * 7), 1'b0, 4'(c));
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset values while reset is held
    check1("R8 flags in reset", {61'd0, flag_of, flag_zf, flag_sf}, 64'b010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #(PERIOD/4);
    check1("R8 flags after release", {61'd0, flag_of, flag_zf, flag_sf}, 64'b010);
    sweep("reset state");

    drive("R1 R4 add plain", 2'd0, 64'd5, 64'd7, 1'b1, 4'd6);
    drive("R2 R4 sub negative", 2'd1, 64'd9, 64'd4, 1'b1, 4'd2);
    drive("R5 add pos overflow", 2'd0, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 4'd6);
    sweep("pos ovf");
    drive("R5 add neg overflow to zero", 2'd0, 64'h8000_0000_0000_0000,
          64'h8000_0000_0000_0000, 1'b1, 4'd1);
    sweep("ovf zero");
    drive("R6 sub overflow", 2'd1, 64'd1, 64'h8000_0000_0000_0000, 1'b1, 4'd5);
    sweep("sub ovf");
    drive("R6 sub no ovf mixed sign", 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b1, 4'd6);
    drive("R2 R4 sub equal", 2'd1, 64'h1234, 64'h1234, 1'b1, 4'd3);
    drive("R5 add overflow", 2'd0, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1, 4'd2);
    drive("R3 R6 and clears of", 2'd2, 64'hF0F0_0000_0000_00FF, 64'hFF00_0000_0000_0F0F, 1'b1, 4'd2);
    sweep("and");
    drive("R3 R4 xor zero", 2'd3, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001, 1'b1, 4'd4);
    drive("R3 xor", 2'd3, 64'h0F0F, 64'hFFFF, 1'b1, 4'd5);
    drive("R1 add wrap", 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 4'd3);
    sweep("final");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule